// File: doc/BRIEF.md
# Staged Shadow Register Bank for a Display Pipeline

This block holds a bank of display-pipeline control registers. Each register is held in several copies, so software can prepare new settings without disturbing the frame being drawn. Software writes through a simple register bus into an assembly copy. Some registers keep only assembly and active copies. Others add an intermediate arm copy, which freezes a snapshot of assembly when software asks for it.

A command word carries two request bits for each register group. The low bit of a group requests activation. The bit eight positions above it requests an update (assembly to arm). A commit is a write of the update bit followed by a write of the activation bit. Activation completes at once while the controller's stop input is high. Otherwise it waits for the next frame-start pulse. Until then it stays visible as a pending bit. The active copies leave the block as one flat registered bus that feeds the pipeline.

Top module: `shadow_reg_bank`

## Requirements
- R1: After reset every copy of every register, every pending bit and the read-select bit are zero, and `active_flat` and `rdata` read zero.
- R2: A bus write to address 2+i stores `wdata` in the assembly copy of register i and leaves every active copy unchanged. A write to an unmapped address (above 2+NUM_REGS-1) changes nothing. Reads of an unmapped address return zero.
- R3: Register i belongs to group i mod GROUPS. Writing command-word bit 8+g copies assembly into arm, at that write's clock edge, for every three-copy register in group g. Active copies are unchanged. When the update and activation bits of a group are set in the same write, active receives the arm value held before that write.
- R4: While `stop_mode` is high, a command write with bit g set loads active at that write's edge: from arm for three-copy registers, and from assembly for two-copy registers of group g. A group already pending transfers at the first edge at which `stop_mode` is high.
- R5: While `stop_mode` is low, an activation request leaves active unchanged until the first edge with `frame_start` high. At that edge a two-copy register takes its assembly value as it stands then.
- R6: A command-word read (address 0) returns the pending activation bits in bits GROUPS-1:0 and zero elsewhere, so update bits read as zero. A pending bit clears at the edge of its transfer.
- R7: For a three-copy register, assembly writes made after the update and before the frame boundary do not reach active at that boundary. Active receives the arm value captured at update time.
- R8: Address 1 bit 0 is a read-select bit. When it is 0, register reads return the active copy. When it is 1, they return the assembly copy. Read data appear on `rdata` the cycle after `rd_en`, and hold otherwise.
- R9: Requests for one group never change active copies of registers in another group.
- R10: A `frame_start` pulse with no pending request changes no active copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_mode | input | 1 | High when the controller is stopped; activation completes at once |
| frame_start | input | 1 | One-cycle frame-boundary pulse |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | ADDR_W | Word address: 0 command, 1 read select, 2+i register i |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| active_flat | output | NUM_REGS*DATA_W | Active copies, register i in bits i*DATA_W upward |

## Verification
The assertions assume that `stop_mode`, `frame_start`, `wr_en`, `rd_en` and `addr` are synchronous to `clk` and carry no unknown value once reset is released. They also assume that reset is held across at least one rising edge. The stimulus changes every input only on the falling edge and keeps reset high for several edges. It drives `frame_start` as isolated single-cycle pulses and changes `stop_mode` only between bus operations. Under these conditions the arm-sourcing and stability properties describe real transfers rather than input glitches.

// File: rtl/shadow_bank_pkg.sv
package shadow_bank_pkg;
  localparam int unsigned CMD_ADDR   = 0;
  localparam int unsigned RDSEL_ADDR = 1;
  localparam int unsigned REG_BASE   = 2;
  localparam int unsigned UPD_SHIFT  = 8;

  typedef enum logic { COPIES_TWO = 1'b0, COPIES_THREE = 1'b1 } copies_e;

  function automatic int unsigned group_of(input int unsigned idx, input int unsigned groups);
    return idx % groups;
  endfunction
endpackage

// File: rtl/sb_cmd_ctrl.sv
module sb_cmd_ctrl import shadow_bank_pkg::*; #(
  parameter int unsigned GROUPS = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              stop_mode,
  input  logic              frame_start,
  output logic [GROUPS-1:0] upd_req,
  output logic [GROUPS-1:0] xfer,
  output logic [GROUPS-1:0] pending
);
  logic [GROUPS-1:0] act_req;

  always_comb begin
    act_req = cmd_wr ? cmd_wdata[GROUPS-1:0] : '0;
    upd_req = cmd_wr ? cmd_wdata[UPD_SHIFT +: GROUPS] : '0;
    xfer    = (pending | act_req) & {GROUPS{stop_mode | frame_start}};
  end

  always_ff @(posedge clk) begin
    if (rst) pending <= '0;
    else     pending <= (pending | act_req) & ~xfer;
  end

  // R6
  pending_rise_chk: assert property (@(posedge clk) disable iff (rst)
    !cmd_wr |=> ((pending & ~$past(pending)) == '0));

  // R4
  stop_drains_chk: assert property (@(posedge clk) disable iff (rst)
    stop_mode |=> (pending == '0));
endmodule

// File: rtl/sb_reg_slot.sv
module sb_reg_slot import shadow_bank_pkg::*; #(
  parameter int unsigned DATA_W = 32,
  parameter copies_e     COPIES = COPIES_TWO
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              asm_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              upd,
  input  logic              xfer,
  output logic [DATA_W-1:0] asm_q,
  output logic [DATA_W-1:0] active_q
);
  logic [DATA_W-1:0] src;

  always_ff @(posedge clk) begin
    if (rst)         asm_q <= '0;
    else if (asm_we) asm_q <= wdata;
  end

  generate
    if (COPIES == COPIES_THREE) begin : g_arm
      logic [DATA_W-1:0] arm_q;
      always_ff @(posedge clk) begin
        if (rst)      arm_q <= '0;
        else if (upd) arm_q <= asm_q;
      end
      assign src = arm_q;

      // R3
      arm_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(arm_q));

      // R7
      active_from_arm_chk: assert property (@(posedge clk) disable iff (rst)
        xfer |=> (active_q == $past(arm_q)));
    end else begin : g_noarm
      logic unused_upd;
      assign unused_upd = upd;
      assign src = asm_q;

      // R5
      active_from_asm_chk: assert property (@(posedge clk) disable iff (rst)
        xfer |=> (active_q == $past(asm_q)));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)       active_q <= '0;
    else if (xfer) active_q <= src;
  end

  // R4
  active_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !xfer |=> $stable(active_q));
endmodule

// File: rtl/sb_read_mux.sv
module sb_read_mux import shadow_bank_pkg::*; #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned GROUPS   = 4,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rd_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       rdsel,
  input  logic [GROUPS-1:0]          pending,
  input  logic [NUM_REGS*DATA_W-1:0] asm_flat,
  input  logic [NUM_REGS*DATA_W-1:0] act_flat,
  output logic [DATA_W-1:0]          rdata
);
  logic [DATA_W-1:0] rd_d;

  always_comb begin
    rd_d = '0;
    if (addr == ADDR_W'(CMD_ADDR)) begin
      rd_d[GROUPS-1:0] = pending;
    end else if (addr == ADDR_W'(RDSEL_ADDR)) begin
      rd_d[0] = rdsel;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (addr == ADDR_W'(REG_BASE + i))
          rd_d = rdsel ? asm_flat[i*DATA_W +: DATA_W] : act_flat[i*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_d;
  end

  // R8
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: rtl/shadow_reg_bank.sv
module shadow_reg_bank import shadow_bank_pkg::*; #(
  parameter int unsigned         DATA_W      = 32,
  parameter int unsigned         NUM_REGS    = 8,
  parameter int unsigned         GROUPS      = 4,
  parameter int unsigned         ADDR_W      = 4,
  parameter logic [NUM_REGS-1:0] TRIPLE_MASK = 'hF0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       stop_mode,
  input  logic                       frame_start,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          rdata,
  output logic [NUM_REGS*DATA_W-1:0] active_flat
);
  localparam int unsigned FLAT_W = NUM_REGS * DATA_W;

  logic                cmd_wr;
  logic                rdsel;
  logic [NUM_REGS-1:0] reg_we;
  logic [GROUPS-1:0]   upd_req;
  logic [GROUPS-1:0]   xfer;
  logic [GROUPS-1:0]   pending;
  logic [FLAT_W-1:0]   asm_flat;

  assign cmd_wr = wr_en && (addr == ADDR_W'(CMD_ADDR));

  always_ff @(posedge clk) begin
    if (rst)                                         rdsel <= 1'b0;
    else if (wr_en && addr == ADDR_W'(RDSEL_ADDR))   rdsel <= wdata[0];
  end

  sb_cmd_ctrl #(.GROUPS(GROUPS), .DATA_W(DATA_W)) u_cmd (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_wdata(wdata),
    .stop_mode(stop_mode), .frame_start(frame_start),
    .upd_req(upd_req), .xfer(xfer), .pending(pending)
  );

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
      localparam copies_e     KIND = TRIPLE_MASK[i] ? COPIES_THREE : COPIES_TWO;
      localparam int unsigned GRP  = group_of(i, GROUPS);

      assign reg_we[i] = wr_en && (addr == ADDR_W'(REG_BASE + i));

      sb_reg_slot #(.DATA_W(DATA_W), .COPIES(KIND)) u_slot (
        .clk(clk), .rst(rst), .asm_we(reg_we[i]), .wdata(wdata),
        .upd(upd_req[GRP]), .xfer(xfer[GRP]),
        .asm_q(asm_flat[i*DATA_W +: DATA_W]),
        .active_q(active_flat[i*DATA_W +: DATA_W])
      );
    end
  endgenerate

  sb_read_mux #(.NUM_REGS(NUM_REGS), .GROUPS(GROUPS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .rdsel(rdsel),
    .pending(pending), .asm_flat(asm_flat), .act_flat(active_flat), .rdata(rdata)
  );

  // R5
  running_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!stop_mode && !frame_start) |=> $stable(active_flat));

  // R10
  idle_frame_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_start && !stop_mode && pending == '0 && !cmd_wr) |=> $stable(active_flat));
endmodule

// File: tb/shadow_reg_bank_test.sv
`timescale 1ns/1ps
module shadow_reg_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int NR = 8;
  localparam int NG = 4;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stop_mode = 1'b0, frame_start = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [NR*DW-1:0] active_flat;

  int checks = 0;
  int failures = 0;
  bit model_on = 1'b0;

  shadow_reg_bank uut (
    .clk(clk), .rst(rst), .stop_mode(stop_mode), .frame_start(frame_start),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .active_flat(active_flat)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  logic [DW-1:0] m_asm [NR];
  logic [DW-1:0] m_arm [NR];
  logic [DW-1:0] m_act [NR];
  logic [NG-1:0] m_pend;
  logic          m_sel;
  logic [DW-1:0] m_rdata;

  always @(posedge clk) begin : model
    logic [NG-1:0] act_b, upd_b, xf;
    if (rst) begin
      for (int i = 0; i < NR; i++) begin m_asm[i] = 0; m_arm[i] = 0; m_act[i] = 0; end
      m_pend = 0; m_sel = 0; m_rdata = 0;
    end else begin
      act_b = (wr_en && addr == 0) ? wdata[NG-1:0] : '0;
      upd_b = (wr_en && addr == 0) ? wdata[8 +: NG] : '0;
      xf = (m_pend | act_b) & {NG{stop_mode | frame_start}};
      if (rd_en) begin
        if (addr == 0) m_rdata = {{(DW-NG){1'b0}}, m_pend};
        else if (addr == 1) m_rdata = {31'b0, m_sel};
        else if (int'(addr) >= 2 && int'(addr) < 2 + NR)
          m_rdata = m_sel ? m_asm[int'(addr) - 2] : m_act[int'(addr) - 2];
        else m_rdata = 0;
      end
      for (int i = 0; i < NR; i++) begin
        if (xf[i % NG]) m_act[i] = (i >= 4) ? m_arm[i] : m_asm[i];
        if (upd_b[i % NG] && i >= 4) m_arm[i] = m_asm[i];
        if (wr_en && int'(addr) == 2 + i) m_asm[i] = wdata;
      end
      m_pend = (m_pend | act_b) & ~xf;
      if (wr_en && addr == 1) m_sel = wdata[0];
    end
  end

  always @(negedge clk) begin
    if (model_on && !rst) begin
      logic bad;
      bad = (rdata !== m_rdata);
      for (int i = 0; i < NR; i++)
        if (active_flat[i*DW +: DW] !== m_act[i]) bad = 1'b1;
      checks++;
      if (bad) begin
        failures++;
        $display("FAIL R9 model compare at %0t: rdata act=%h exp=%h active act=%h", $time, rdata, m_rdata, active_flat);
      end
    end
  end

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] actv(input int i);
    return active_flat[i*DW +: DW];
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic pulse_frame();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stimulus
    logic [DW-1:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    model_on = 1'b1;

    // R1 reset state
    chk("R1 active bus zero", DW'(|active_flat), 0);
    rd(0, v); chk("R1 command word zero", v, 0);
    rd(2, v); chk("R1 reg0 zero", v, 0);

    // R2 assembly writes do not reach active
    wr(2, 32'hA1);
    wr(6, 32'hB1);
    chk("R2 reg0 active unchanged", actv(0), 0);
    rd(2, v); chk("R2 reg0 read active", v, 0);
    // R8 read select picks assembly
    wr(1, 1);
    rd(2, v); chk("R8 reg0 read assembly", v, 32'hA1);
    rd(1, v); chk("R8 select readback", v, 1);
    wr(1, 0);

    // R3 update copies to arm only
    wr(0, 32'h100);
    chk("R3 reg4 active unchanged after update", actv(4), 0);

    // R5 / R6 activation pending while running
    wr(0, 32'h1);
    rd(0, v); chk("R6 pending group0", v, 1);
    chk("R5 reg0 waits for frame", actv(0), 0);

    // R7 late assembly writes
    wr(6, 32'hB2);
    wr(2, 32'hA2);
    pulse_frame();
    chk("R7 reg4 takes arm value", actv(4), 32'hB1);
    chk("R5 reg0 takes assembly at frame", actv(0), 32'hA2);
    rd(0, v); chk("R6 pending cleared", v, 0);
    chk("R9 reg1 untouched", actv(1), 0);
    chk("R9 reg5 untouched", actv(5), 0);

    // R10 idle frame
    pulse_frame();
    chk("R10 reg4 stable", actv(4), 32'hB1);
    chk("R10 reg0 stable", actv(0), 32'hA2);

    // R4 stop mode: immediate transfer
    @(negedge clk); stop_mode = 1'b1;
    wr(3, 32'hC1);
    wr(0, 32'h2);
    chk("R4 reg1 immediate", actv(1), 32'hC1);
    rd(0, v); chk("R4 no pending in stop", v, 0);
    wr(7, 32'hD1);
    wr(0, 32'h200);
    wr(0, 32'h2);
    chk("R4 reg5 from arm", actv(5), 32'hD1);
    wr(7, 32'hD2);
    wr(0, 32'h202);
    chk("R3 combined word uses old arm", actv(5), 32'hD1);
    wr(0, 32'h2);
    chk("R4 reg5 second commit", actv(5), 32'hD2);
    chk("R9 reg0 other group stable", actv(0), 32'hA2);

    // R6 update bits read as zero
    @(negedge clk); stop_mode = 1'b0;
    wr(0, 32'h100);
    rd(0, v); chk("R6 update bit reads zero", v, 0);
    chk("R3 reg4 active after lone update", actv(4), 32'hB1);

    // R2 unmapped address
    wr(15, 32'hFFFF_FFFF);
    rd(15, v); chk("R2 unmapped read zero", v, 0);
    rd(1, v); chk("R2 select unaffected", v, 0);
    chk("R2 reg0 unaffected", actv(0), 32'hA2);

    // R4 pending drains when stop rises
    wr(4, 32'hE1);
    wr(0, 32'h4);
    rd(0, v); chk("R6 pending group2", v, 4);
    chk("R5 reg2 waits", actv(2), 0);
    @(negedge clk); stop_mode = 1'b1;
    @(negedge clk);
    chk("R4 pending drains on stop", actv(2), 32'hE1);
    rd(0, v); chk("R6 pending clear after stop", v, 0);
    @(negedge clk); stop_mode = 1'b0;

    repeat (3) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule